// File: doc/BRIEF.md
# Two-Bank 16-bit Dual-Port Word Memory

This block builds one 16-bit wide, two-port memory out of two byte-wide banks. The left and right buses each carry a select, a write flag, an address and a 16-bit data word. Bit 7 to bit 0 of each word go to the master bank and bit 15 to bit 8 go to the slave bank. Either port may read or write any location at any time. When both ports select the same address in the same cycle, one of them is refused, and the refused port learns this through its busy flag.

Only the master bank has an arbiter. The slave bank has no arbitration of its own. It runs one cycle behind the master on a registered copy of each port's request, and the master's busy flag for each port gates its writes. This models the master's arbitration settling time. Because one arbiter decides for both bytes, the two banks can never refuse different ports for the same access. A word is therefore never made of bytes that came from different ports, and the ports cannot block each other in a lock-out.

A refused port is expected to keep driving its request. The write then goes through, in both banks, on the first cycle in which that port is no longer refused.

Top module: `dual_bank_wide_ram`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, both busy flags read 0 and both read-data buses read 0.
- R2: A word written through either port is stored with bits 7:0 in the master bank and bits 15:8 in the slave bank. A later read of that address through either port returns the whole 16-bit word, two clock edges after the read is presented.
- R3: A conflict exists when both ports are selected with equal addresses, whatever their write flags. On the edge after a conflict cycle, exactly one busy flag reads 1. Busy is never 1 on both ports, and never 1 without a conflict in the previous cycle.
- R4: When a conflict starts, a port that was already selected on that same address in the previous cycle, while the other port was not, wins. If both ports arrive together, the left port wins (the default tie setting).
- R5: As long as the conflict continues from one cycle to the next, the same port keeps winning.
- R6: A write from the refused port changes neither byte of the addressed word.
- R7: The slave bank writes a port's high byte exactly one cycle after the master bank writes that port's low byte. It never writes for a port whose busy input is 1.
- R8: A refused write that is held until the conflict ends is written in full, in both bytes, once that port is no longer refused.
- R9: Reads are served even while refused. A read that is presented in the same cycle as a refused write to the same address returns the word as it was before that cycle.
- R10: A read presented in the cycle right after a write to the same address, from either port, returns the new 16-bit word with both bytes updated.
- R11: After any sequence of contended writes, every word reads back equal to one value that a single port wrote in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left port selected |
| l_wr | input | 1 | Left port write (1) or read (0) |
| l_addr | input | AW (10) | Left port word address |
| l_wdata | input | 16 | Left port write word |
| l_rdata | output | 16 | Left port read word, registered |
| l_busy | output | 1 | Left port refused by the arbiter, registered |
| r_sel | input | 1 | Right port selected |
| r_wr | input | 1 | Right port write (1) or read (0) |
| r_addr | input | AW (10) | Right port word address |
| r_wdata | input | 16 | Right port write word |
| r_rdata | output | 16 | Right port read word, registered |
| r_busy | output | 1 | Right port refused by the arbiter, registered |

## Verification
A request is presented in one cycle. The busy verdict for that request is due one edge later, and the read word is due two edges later, because the low byte waits one extra stage to line up with the slave byte. The bench drives inputs on the falling edge and checks busy on the next falling edge. For reads, it holds an idle cycle and then checks the data on the falling edge after the second rising edge. Write contents are never probed directly: each one is proven by a read issued afterwards, including a read in the very next cycle to expose the one-cycle lag of the slave bank.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  // which port currently holds a contested address
  typedef enum logic {
    OWN_LEFT  = 1'b0,
    OWN_RIGHT = 1'b1
  } owner_e;
endpackage

// File: rtl/dbw_arbiter.sv
module dbw_arbiter
  import dbw_pkg::*;
#(
  parameter int AW        = 10,
  parameter bit TIE_RIGHT = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_sel,
  input  logic          r_sel,
  input  logic [AW-1:0] l_addr,
  input  logic [AW-1:0] r_addr,
  output logic          l_block,
  output logic          r_block,
  output logic          l_busy_q,
  output logic          r_busy_q
);
  logic          clash, clash_q;
  logic          l_prev_sel, r_prev_sel;
  logic [AW-1:0] l_prev_addr, r_prev_addr;
  logic          l_held, r_held;
  owner_e        owner_q, owner_d;

  assign clash  = l_sel && r_sel && (l_addr == r_addr);
  assign l_held = l_prev_sel && (l_prev_addr == l_addr);
  assign r_held = r_prev_sel && (r_prev_addr == r_addr);

  always_comb begin
    owner_d = owner_q;
    if (clash && !clash_q) begin
      if (r_held && !l_held)      owner_d = OWN_RIGHT;
      else if (l_held && !r_held) owner_d = OWN_LEFT;
      else                        owner_d = TIE_RIGHT ? OWN_RIGHT : OWN_LEFT;
    end
  end

  assign l_block = clash && (owner_d == OWN_RIGHT);
  assign r_block = clash && (owner_d == OWN_LEFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      clash_q     <= 1'b0;
      owner_q     <= OWN_LEFT;
      l_prev_sel  <= 1'b0;
      r_prev_sel  <= 1'b0;
      l_prev_addr <= '0;
      r_prev_addr <= '0;
      l_busy_q    <= 1'b0;
      r_busy_q    <= 1'b0;
    end else begin
      clash_q     <= clash;
      owner_q     <= owner_d;
      l_prev_sel  <= l_sel;
      r_prev_sel  <= r_sel;
      l_prev_addr <= l_addr;
      r_prev_addr <= r_addr;
      l_busy_q    <= l_block;
      r_busy_q    <= r_block;
    end
  end

  // R3
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(l_busy_q && r_busy_q));

  // R3
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (l_busy_q || r_busy_q) |-> $past(l_sel && r_sel && (l_addr == r_addr)));

  // R5
  owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (r_busy_q && l_sel && r_sel && (l_addr == r_addr)) |=> r_busy_q);
endmodule

// File: rtl/dbw_bank.sv
module dbw_bank #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_rd,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_rd,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= mem[a_addr];
      if (b_rd) b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/dbw_stage.sv
module dbw_stage #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          sel_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o  <= 1'b0;
      wr_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      sel_o  <= sel_i;
      wr_o   <= wr_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/dual_bank_wide_ram.sv
module dual_bank_wide_ram #(
  parameter int AW        = 10,
  parameter int BW        = 8,
  parameter bit TIE_RIGHT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               l_sel,
  input  logic               l_wr,
  input  logic [AW-1:0]      l_addr,
  input  logic [2*BW-1:0]    l_wdata,
  output logic [2*BW-1:0]    l_rdata,
  output logic               l_busy,
  input  logic               r_sel,
  input  logic               r_wr,
  input  logic [AW-1:0]      r_addr,
  input  logic [2*BW-1:0]    r_wdata,
  output logic [2*BW-1:0]    r_rdata,
  output logic               r_busy
);
  localparam int WW = 2 * BW;

  logic l_block, r_block;
  logic ms_l_wr, ms_r_wr, ms_l_rd, ms_r_rd;
  logic [BW-1:0] ms_l_q, ms_r_q, lo_l_q, lo_r_q;

  logic          ds_l_sel, ds_l_wr, ds_r_sel, ds_r_wr;
  logic [AW-1:0] ds_l_addr, ds_r_addr;
  logic [BW-1:0] ds_l_data, ds_r_data;
  logic          sl_l_wr, sl_r_wr, sl_l_rd, sl_r_rd;
  logic [BW-1:0] sl_l_q, sl_r_q;

  // single arbiter, on the master side only
  dbw_arbiter #(.AW(AW), .TIE_RIGHT(TIE_RIGHT)) u_arb (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .r_sel(r_sel), .l_addr(l_addr), .r_addr(r_addr),
    .l_block(l_block), .r_block(r_block),
    .l_busy_q(l_busy), .r_busy_q(r_busy)
  );

  // master bank: low byte, gated by the arbiter decision of this cycle
  assign ms_l_wr = l_sel && l_wr && !l_block;
  assign ms_r_wr = r_sel && r_wr && !r_block;
  assign ms_l_rd = l_sel && !l_wr;
  assign ms_r_rd = r_sel && !r_wr;

  dbw_bank #(.AW(AW), .DW(BW)) u_master (
    .clk(clk), .rst(rst),
    .a_rd(ms_l_rd), .a_wr(ms_l_wr), .a_addr(l_addr),
    .a_wdata(l_wdata[BW-1:0]), .a_rdata(ms_l_q),
    .b_rd(ms_r_rd), .b_wr(ms_r_wr), .b_addr(r_addr),
    .b_wdata(r_wdata[BW-1:0]), .b_rdata(ms_r_q)
  );

  // one-cycle copies of each request feed the slave bank
  dbw_stage #(.AW(AW), .DW(BW)) u_l_stage (
    .clk(clk), .rst(rst),
    .sel_i(l_sel), .wr_i(l_wr), .addr_i(l_addr), .data_i(l_wdata[WW-1:BW]),
    .sel_o(ds_l_sel), .wr_o(ds_l_wr), .addr_o(ds_l_addr), .data_o(ds_l_data)
  );

  dbw_stage #(.AW(AW), .DW(BW)) u_r_stage (
    .clk(clk), .rst(rst),
    .sel_i(r_sel), .wr_i(r_wr), .addr_i(r_addr), .data_i(r_wdata[WW-1:BW]),
    .sel_o(ds_r_sel), .wr_o(ds_r_wr), .addr_o(ds_r_addr), .data_o(ds_r_data)
  );

  // slave bank: high byte, gated only by the master's settled busy flags
  assign sl_l_wr = ds_l_sel && ds_l_wr && !l_busy;
  assign sl_r_wr = ds_r_sel && ds_r_wr && !r_busy;
  assign sl_l_rd = ds_l_sel && !ds_l_wr;
  assign sl_r_rd = ds_r_sel && !ds_r_wr;

  dbw_bank #(.AW(AW), .DW(BW)) u_slave (
    .clk(clk), .rst(rst),
    .a_rd(sl_l_rd), .a_wr(sl_l_wr), .a_addr(ds_l_addr),
    .a_wdata(ds_l_data), .a_rdata(sl_l_q),
    .b_rd(sl_r_rd), .b_wr(sl_r_wr), .b_addr(ds_r_addr),
    .b_wdata(ds_r_data), .b_rdata(sl_r_q)
  );

  // align the master byte with the later slave byte
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_l_q <= '0;
      lo_r_q <= '0;
    end else begin
      if (sl_l_rd) lo_l_q <= ms_l_q;
      if (sl_r_rd) lo_r_q <= ms_r_q;
    end
  end

  assign l_rdata = {sl_l_q, lo_l_q};
  assign r_rdata = {sl_r_q, lo_r_q};

  // R7
  l_slave_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sl_l_wr |-> $past(ms_l_wr));
  // R7
  l_master_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    ms_l_wr |=> sl_l_wr);
  // R7
  r_slave_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sl_r_wr |-> $past(ms_r_wr));
  // R7
  r_master_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    ms_r_wr |=> sl_r_wr);
  // R11
  slave_addr_match_chk: assert property (@(posedge clk) disable iff (rst)
    sl_l_wr |-> (ds_l_addr == $past(l_addr)));
endmodule

// File: tb/tb_dual_bank_wide_ram.sv
`timescale 1ns/1ps
module tb_dual_bank_wide_ram;
  localparam int AW = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic          ls;
    logic          lw;
    logic [AW-1:0] la;
    logic [15:0]   ld;
    logic          rs;
    logic          rw;
    logic [AW-1:0] ra;
    logic [15:0]   rd;
    logic          xl;
    logic          xr;
  } vec_t;

  // one cycle of stimulus per entry, with the expected busy flags
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,10'h010,16'h1111, 1'b0,1'b0,10'h000,16'h0000, 1'b0,1'b0},
    '{1'b1,1'b1,10'h011,16'h3333, 1'b1,1'b1,10'h020,16'h2222, 1'b0,1'b0},
    '{1'b1,1'b1,10'h030,16'hAAAA, 1'b1,1'b1,10'h030,16'h5555, 1'b0,1'b1},
    '{1'b0,1'b0,10'h000,16'h0000, 1'b0,1'b0,10'h000,16'h0000, 1'b0,1'b0},
    '{1'b1,1'b1,10'h040,16'h4444, 1'b0,1'b0,10'h000,16'h0000, 1'b0,1'b0},
    '{1'b1,1'b1,10'h040,16'h4444, 1'b1,1'b1,10'h040,16'h7777, 1'b0,1'b1},
    '{1'b1,1'b1,10'h040,16'h4444, 1'b1,1'b1,10'h040,16'h7777, 1'b0,1'b1},
    '{1'b0,1'b0,10'h000,16'h0000, 1'b1,1'b1,10'h040,16'h7777, 1'b0,1'b0},
    '{1'b0,1'b0,10'h000,16'h0000, 1'b1,1'b1,10'h050,16'h1234, 1'b0,1'b0},
    '{1'b1,1'b1,10'h050,16'hBEEF, 1'b1,1'b1,10'h050,16'h1234, 1'b1,1'b0},
    '{1'b1,1'b1,10'h050,16'hBEEF, 1'b0,1'b0,10'h000,16'h0000, 1'b0,1'b0},
    '{1'b1,1'b0,10'h010,16'h0000, 1'b1,1'b0,10'h010,16'h0000, 1'b0,1'b1},
    '{1'b1,1'b1,10'h060,16'h0F0F, 1'b1,1'b0,10'h010,16'h0000, 1'b0,1'b0}
  };

  localparam logic [AW-1:0] ADDRS [7] = '{10'h010, 10'h011, 10'h020, 10'h030,
                                          10'h040, 10'h050, 10'h060};

  logic          clk = 1'b0;
  logic          rst;
  logic          l_sel, l_wr, r_sel, r_wr;
  logic [AW-1:0] l_addr, r_addr;
  logic [15:0]   l_wdata, r_wdata, l_rdata, r_rdata;
  logic          l_busy, r_busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] model [1 << AW];

  always #4 clk = ~clk;

  dual_bank_wide_ram #(.AW(AW)) dut (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy(l_busy),
    .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy(r_busy)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ls, input logic lw, input logic [AW-1:0] la,
                       input logic [15:0] ld, input logic rs, input logic rw,
                       input logic [AW-1:0] ra, input logic [15:0] rd);
    l_sel = ls; l_wr = lw; l_addr = la; l_wdata = ld;
    r_sel = rs; r_wr = rw; r_addr = ra; r_wdata = rd;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
  endtask

  // read through one port; the word is due after the second rising edge
  task automatic read_word(input bit right, input logic [AW-1:0] a,
                           input logic [15:0] exp, input string tag);
    if (right) drive(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, a, '0);
    else       drive(1'b1, 1'b0, a, '0, 1'b0, 1'b0, '0, '0);
    step();
    idle();
    step();
    chk(tag, right ? r_rdata : l_rdata, exp);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = 16'h0000;
    rst = 1'b1;
    idle();
    repeat (3) step();
    // R1: reset state
    chk("R1 l_busy in reset", {15'd0, l_busy}, 16'h0000);
    chk("R1 r_busy in reset", {15'd0, r_busy}, 16'h0000);
    chk("R1 l_rdata in reset", l_rdata, 16'h0000);
    rst = 1'b0;
    step();
    chk("R1 r_rdata after reset", r_rdata, 16'h0000);

    // table: R3 R4 R5 R6 R8 busy verdicts one edge after each vector
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v.ls, v.lw, v.la, v.ld, v.rs, v.rw, v.ra, v.rd);
      step();
      chk($sformatf("R3/R4/R5 l_busy vector %0d", i), {15'd0, l_busy}, {15'd0, v.xl});
      chk($sformatf("R3/R4/R5 r_busy vector %0d", i), {15'd0, r_busy}, {15'd0, v.xr});
      if (v.ls && v.lw && !v.xl) model[v.la] = v.ld;
      if (v.rs && v.rw && !v.xr) model[v.ra] = v.rd;
    end
    idle();
    step();

    // R2 R6 R8 R11: every word reads whole, from both ports
    for (int k = 0; k < 7; k++) begin
      read_word(1'b0, ADDRS[k], model[ADDRS[k]], $sformatf("R2/R11 left read %h", ADDRS[k]));
      read_word(1'b1, ADDRS[k], model[ADDRS[k]], $sformatf("R6/R8 right read %h", ADDRS[k]));
    end

    // R10: write then read in the very next cycle from the other port
    drive(1'b1, 1'b1, 10'h070, 16'h9999, 1'b0, 1'b0, '0, '0);
    step();
    read_word(1'b1, 10'h070, 16'h9999, "R10 right read right after left write");
    drive(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 10'h071, 16'hC3A5);
    step();
    read_word(1'b0, 10'h071, 16'hC3A5, "R10 left read right after right write");

    // R9: left read and right write meet on one address; left wins the tie
    drive(1'b1, 1'b0, 10'h060, 16'h0000, 1'b1, 1'b1, 10'h060, 16'hDEAD);
    step();
    chk("R3 r_busy on read/write clash", {15'd0, r_busy}, 16'h0001);
    idle();
    step();
    chk("R9 read during refused write", l_rdata, 16'h0F0F);
    read_word(1'b1, 10'h060, 16'h0F0F, "R6 refused write left word intact");

    // R1: reset again after activity
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1 l_rdata after second reset", l_rdata, 16'h0000);
    chk("R1 l_busy after second reset", {15'd0, l_busy}, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule